// File: doc/BRIEF.md
# Two-Write-Port Register File with Operand Decode

This block holds the eight 32-bit general registers of a small single-cycle processor and the decode logic that chooses which registers an instruction reads and writes. From the 4-bit opcode, the two register fields of the instruction and the condition flag from the execute stage, it produces two source IDs and two destination IDs. It then reads the two source registers combinationally.

The block has two write ports. Port E takes the ALU result and port M takes the value loaded from memory. Both update on the rising clock edge. The 4-bit ID 0xF means "no register" on any port.

The opcode encoding is: 0 halt, 1 nop, 2 register/conditional move, 3 immediate move, 4 store, 5 load, 6 arithmetic, 7 jump, 8 call, 9 return, 0xA push, 0xB pop. Codes 0xC to 0xF are undefined. Register IDs 0 to 7 select a register, and ID 4 is the stack pointer.

Top module: `regfile_decode`

## Requirements
- R1: A synchronous reset, active high, clears every register to zero. After reset, any read of IDs 0 to 7 returns 0.
- R2: src_a is ra for opcodes 2, 4, 6 and 0xA. It is 4 for opcodes 9 and 0xB. It is 0xF for every other opcode.
- R3: src_b is rb for opcodes 4, 5 and 6. It is 4 for opcodes 8, 9, 0xA and 0xB. It is 0xF for every other opcode.
- R4: dst_e is rb for opcode 2 only while cond is 1, and 0xF for opcode 2 while cond is 0. It is rb for opcodes 3 and 6. It is 4 for opcodes 8, 9, 0xA and 0xB. It is 0xF for every other opcode.
- R5: dst_m is ra for opcodes 5 and 0xB, and 0xF for every other opcode.
- R6: A read port whose ID is 0xF returns 0. A write port whose ID is 0xF changes no register.
- R7: Reads are combinational. A write takes effect only at the rising clock edge. Before that edge, a read of the target register returns the old value.
- R8: When dst_e and dst_m name the same register in one cycle, that register takes val_m.
- R9: When dst_e and dst_m name different registers, both registers are written in the same cycle.
- R10: Undefined opcodes 0xC to 0xF drive all four IDs to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Instruction opcode |
| ra | input | 4 | First register field of the instruction |
| rb | input | 4 | Second register field of the instruction |
| cond | input | 1 | Condition flag for conditional moves |
| val_e | input | 32 | Write data for port E |
| val_m | input | 32 | Write data for port M |
| src_a | output | 4 | Read port A register ID |
| src_b | output | 4 | Read port B register ID |
| dst_e | output | 4 | Write port E register ID |
| dst_m | output | 4 | Write port M register ID |
| val_a | output | 32 | Data read on port A |
| val_b | output | 32 | Data read on port B |

## Verification
Decoded IDs and read data are combinational, so they are due in the same cycle as the inputs that produce them. A write is due one rising edge after the cycle in which its ID and data are presented. The bench changes inputs on the falling edge and checks combinational results 1 ns later, well before the next rising edge. It checks the effect of a write only after that edge, and it also confirms the old value just before the edge.

// File: rtl/regfile_decode.sv
module regfile_decode #(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int IDW   = 4,
  parameter int SP_ID = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op,
  input  logic [IDW-1:0] ra,
  input  logic [IDW-1:0] rb,
  input  logic           cond,
  input  logic [DW-1:0]  val_e,
  input  logic [DW-1:0]  val_m,
  output logic [IDW-1:0] src_a,
  output logic [IDW-1:0] src_b,
  output logic [IDW-1:0] dst_e,
  output logic [IDW-1:0] dst_m,
  output logic [DW-1:0]  val_a,
  output logic [DW-1:0]  val_b
);
  localparam int AW = $clog2(NREG);
  localparam logic [IDW-1:0] NONE = '1;
  localparam logic [IDW-1:0] SP = IDW'(SP_ID);

  localparam logic [3:0] OP_MOV = 4'h2, OP_IMM = 4'h3, OP_ST  = 4'h4,
                         OP_LD  = 4'h5, OP_ALU = 4'h6, OP_CALL = 4'h8,
                         OP_RET = 4'h9, OP_PUSH = 4'hA, OP_POP = 4'hB;

  logic [DW-1:0] rf [NREG];

  always_comb begin
    src_a = NONE;
    src_b = NONE;
    dst_e = NONE;
    dst_m = NONE;
    case (op)
      OP_MOV:  begin src_a = ra; if (cond) dst_e = rb; end
      OP_IMM:  dst_e = rb;
      OP_ST:   begin src_a = ra; src_b = rb; end
      OP_LD:   begin src_b = rb; dst_m = ra; end
      OP_ALU:  begin src_a = ra; src_b = rb; dst_e = rb; end
      OP_CALL: begin src_b = SP; dst_e = SP; end
      OP_RET:  begin src_a = SP; src_b = SP; dst_e = SP; end
      OP_PUSH: begin src_a = ra; src_b = SP; dst_e = SP; end
      OP_POP:  begin src_a = SP; src_b = SP; dst_e = SP; dst_m = ra; end
      default: ;
    endcase
  end

  assign val_a = (int'(src_a) < NREG) ? rf[src_a[AW-1:0]] : '0;
  assign val_b = (int'(src_b) < NREG) ? rf[src_b[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                     rf[i] <= '0;
      else if (dst_m == IDW'(i))   rf[i] <= val_m;
      else if (dst_e == IDW'(i))   rf[i] <= val_e;
    end
  end
endmodule

// File: rtl/regfile_decode_chk.sv
module regfile_decode_chk #(
  parameter int DW  = 32,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     op,
  input logic           cond,
  input logic [IDW-1:0] src_a,
  input logic [IDW-1:0] dst_e,
  input logic [IDW-1:0] dst_m,
  input logic [DW-1:0]  val_a,
  input logic [DW-1:0]  val_e,
  input logic [DW-1:0]  val_m
);
  localparam logic [IDW-1:0] NONE = '1;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> val_a == '0) else $error("reset"); // R1
  AST_POP_READS_SP: assert property (@(posedge clk) disable iff (rst)
    (op == 4'h9 || op == 4'hB) |-> src_a == IDW'(4)) else $error("pop src"); // R2
  AST_CMOV_FALSE: assert property (@(posedge clk) disable iff (rst)
    (op == 4'h2 && !cond) |-> dst_e == NONE) else $error("cmov"); // R4
  AST_NONE_READ: assert property (@(posedge clk) disable iff (rst)
    src_a == NONE |-> val_a == '0) else $error("none read"); // R6
  AST_E_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dst_e) != NONE && $past(dst_m) != $past(dst_e)
     && src_a == $past(dst_e)) |-> val_a == $past(val_e)) else $error("e write"); // R7
  AST_M_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dst_m) != NONE && src_a == $past(dst_m))
    |-> val_a == $past(val_m)) else $error("m write"); // R8
  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (rst)
    op >= 4'hC |-> (dst_e == NONE && dst_m == NONE)) else $error("undef"); // R10
endmodule

bind regfile_decode regfile_decode_chk #(.DW(DW), .IDW(IDW)) chk (
  .clk(clk), .rst(rst), .op(op), .cond(cond), .src_a(src_a),
  .dst_e(dst_e), .dst_m(dst_m), .val_a(val_a), .val_e(val_e), .val_m(val_m)
);

// File: tb/regfile_decode_test.sv
`timescale 1ns/1ps
module regfile_decode_test;
  logic clk = 0, rst = 1, cond = 0;
  logic [3:0] op = 4'h1, ra = 4'hF, rb = 4'hF;
  logic [31:0] val_e = 0, val_m = 0;
  logic [3:0] src_a, src_b, dst_e, dst_m;
  logic [31:0] val_a, val_b;
  int n_chk = 0, n_bad = 0;

  regfile_decode uut (.clk(clk), .rst(rst), .op(op), .ra(ra), .rb(rb), .cond(cond),
    .val_e(val_e), .val_m(val_m), .src_a(src_a), .src_b(src_b), .dst_e(dst_e),
    .dst_m(dst_m), .val_a(val_a), .val_b(val_b));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [3:0] a, input logic [3:0] b,
                       input logic c, input logic [31:0] e, input logic [31:0] m);
    @(negedge clk);
    op = o; ra = a; rb = b; cond = c; val_e = e; val_m = m;
    #1;
  endtask

  task automatic read_reg(input string tag, input logic [3:0] a, input logic [3:0] b,
                          input logic [31:0] ea, input logic [31:0] eb);
    drive(4'h4, a, b, 0, 0, 0);
    check(tag, val_a, ea);
    check(tag, val_b, eb);
  endtask

  task automatic dec(input string tag, input logic [3:0] o, input logic c,
                     input logic [3:0] xa, input logic [3:0] xb,
                     input logic [3:0] xe, input logic [3:0] xm);
    drive(o, 4'h2, 4'h5, c, 0, 0);
    check({tag, " srcA"}, 32'(src_a), 32'(xa));
    check({tag, " srcB"}, 32'(src_b), 32'(xb));
    check({tag, " dstE"}, 32'(dst_e), 32'(xe));
    check({tag, " dstM"}, 32'(dst_m), 32'(xm));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; op = 4'h1;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_decode();
    dec("R2 R3 R4 R5 halt", 4'h0, 1, 4'hF, 4'hF, 4'hF, 4'hF);
    dec("R2 R3 R4 R5 nop",  4'h1, 1, 4'hF, 4'hF, 4'hF, 4'hF);
    dec("R4 cmov true",     4'h2, 1, 4'h2, 4'hF, 4'h5, 4'hF);
    dec("R4 cmov false",    4'h2, 0, 4'h2, 4'hF, 4'hF, 4'hF);
    dec("R4 imm",           4'h3, 0, 4'hF, 4'hF, 4'h5, 4'hF);
    dec("R2 R3 store",      4'h4, 0, 4'h2, 4'h5, 4'hF, 4'hF);
    dec("R3 R5 load",       4'h5, 0, 4'hF, 4'h5, 4'hF, 4'h2);
    dec("R2 R3 R4 alu",     4'h6, 0, 4'h2, 4'h5, 4'h5, 4'hF);
    dec("R2 R4 jump",       4'h7, 1, 4'hF, 4'hF, 4'hF, 4'hF);
    dec("R3 R4 call",       4'h8, 0, 4'hF, 4'h4, 4'h4, 4'hF);
    dec("R2 R3 R4 ret",     4'h9, 0, 4'h4, 4'h4, 4'h4, 4'hF);
    dec("R2 R3 R4 push",    4'hA, 0, 4'h2, 4'h4, 4'h4, 4'hF);
    dec("R2 R3 R4 R5 pop",  4'hB, 0, 4'h4, 4'h4, 4'h4, 4'h2);
    for (int o = 12; o < 16; o++) dec("R10 undefined", 4'(o), 1, 4'hF, 4'hF, 4'hF, 4'hF);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i += 2) read_reg("R1 reset zero", 4'(i), 4'(i + 1), 0, 0);
  endtask

  task automatic t_edge();
    drive(4'h3, 4'hF, 4'h1, 0, 32'h1111_0001, 0);
    drive(4'h6, 4'h1, 4'h1, 0, 32'hAAAA_5555, 0);
    check("R7 old before edge", val_a, 32'h1111_0001);
    @(posedge clk); #1;
    check("R7 new after edge", val_a, 32'hAAAA_5555);
  endtask

  task automatic t_none();
    drive(4'h3, 4'hF, 4'hF, 0, 32'hDEAD_BEEF, 0);
    drive(4'h4, 4'hF, 4'h1, 0, 0, 0);
    check("R6 none read", val_a, 0);
    check("R6 none write kept r1", val_b, 32'hAAAA_5555);
    read_reg("R6 none write others", 4'h0, 4'h7, 0, 0);
  endtask

  task automatic t_dual();
    drive(4'hB, 4'h4, 4'hF, 0, 32'h0000_E0E0, 32'h0000_F0F0);
    read_reg("R8 M wins", 4'h4, 4'h4, 32'h0000_F0F0, 32'h0000_F0F0);
    drive(4'hB, 4'h2, 4'hF, 0, 32'h0000_0100, 32'h2222_2222);
    read_reg("R9 both written", 4'h4, 4'h2, 32'h0000_0100, 32'h2222_2222);
    drive(4'h5, 4'h6, 4'h4, 0, 0, 32'h6666_0006);
    read_reg("R5 load via M", 4'h6, 4'h4, 32'h6666_0006, 32'h0000_0100);
  endtask

  task automatic t_cmov();
    drive(4'h2, 4'h2, 4'h3, 0, 32'h3333_3333, 0);
    read_reg("R4 cmov false no write", 4'h3, 4'hF, 0, 0);
    drive(4'h2, 4'h2, 4'h3, 1, 32'h3333_3333, 0);
    read_reg("R4 cmov true writes", 4'h3, 4'hF, 32'h3333_3333, 0);
  endtask

  task automatic t_reset_again();
    do_reset();
    read_reg("R1 reset clears", 4'h1, 4'h4, 0, 0);
    read_reg("R1 reset clears", 4'h2, 4'h3, 0, 0);
  endtask

  logic done = 0;
  initial begin
    do_reset();
    t_decode();
    do_reset();
    t_reset();
    t_edge();
    t_none();
    t_dual();
    t_cmov();
    t_reset_again();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule